// File: doc/BRIEF.md
# Addressable control port filter

This block sits between a shared serial control bus and the register file of one device on that bus. It receives transfers that have already been decoded into fields: a device address, a register index, a data byte and a valid flag. For each transfer it decides whether this device should act on it. When the device acts, it raises a one-cycle register write strobe that carries the index and data. The block also keeps the configuration that governs that decision: a 7-bit device address and an enable for address checking.

While address checking is off, every transfer is accepted whatever its address field holds. While it is on, only transfers whose address field equals the stored address are accepted. The control register holds both settings: the enable in its top data bit and the address in the low seven bits.

Addresses are given out one device at a time on a shared bus. An assignment write is a write to the control register with the enable bit set. A device takes such a write only while its data output pin has been released from the external pull-up. A two-state machine follows the pin. In ST_DEAF the pin is held, the output stays tri-stated and assignment writes are dropped. In ST_OPEN the pin is released, the output is driven and assignment writes may be taken. ST_DEAF goes to ST_OPEN on the clock where the release input is sampled high, and ST_OPEN goes back to ST_DEAF on the clock where it is sampled low.

Top module: `ctrl_port_filter`

## Requirements
- R1: After reset, cfg_en is 0, cfg_addr is 0, reg_wr_stb is 0 and dout_oe is 0.
- R2: While cfg_en is 0, a valid transfer to any register index other than 7 is accepted whatever its address field. reg_wr_stb is 1 in the cycle after the transfer, and reg_wr_idx and reg_wr_data carry its index and data. In every other cycle reg_wr_stb is 0.
- R3: While cfg_en is 1, a transfer whose address field differs from cfg_addr produces no strobe and leaves cfg_en and cfg_addr unchanged. A transfer whose address field matches is accepted.
- R4: An accepted write to register index 7 loads cfg_en from data bit 7 and cfg_addr from data bits 6:0. Both take their new values on the clock edge that ends the transfer cycle.
- R5: An assignment write (index 7, data bit 7 set) that arrives while dout_oe is 0 is dropped. No strobe follows, and cfg_en and cfg_addr keep their values. This holds even when the address field matches.
- R6: dout_oe becomes 1 one clock after pin_release is sampled high (ST_DEAF to ST_OPEN), and becomes 0 one clock after pin_release is sampled low (ST_OPEN to ST_DEAF).
- R7: An assignment write that arrives while dout_oe is 1 and passes the address check is accepted. It strobes and stores the new address with cfg_en set to 1.
- R8: A write to index 7 with data bit 7 clear is not gated by the pin state. If it passes the address check, it is accepted while dout_oe is 0, which clears cfg_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_valid | input | 1 | Decoded transfer present this cycle |
| xfer_addr | input | 7 | Device address field of the transfer |
| xfer_idx | input | 3 | Register index of the transfer |
| xfer_data | input | 8 | Data byte of the transfer |
| pin_release | input | 1 | High while the data output pin is released from its pull-up |
| reg_wr_stb | output | 1 | One-cycle write strobe toward the register file |
| reg_wr_idx | output | 3 | Register index of the accepted write |
| reg_wr_data | output | 8 | Data of the accepted write |
| dout_oe | output | 1 | Data output drive enable (0 = tri-stated) |
| cfg_addr | output | 7 | Stored device address |
| cfg_en | output | 1 | Stored address-check enable |

## Verification
Transfers with arbitrary address fields are sent while checking is off, to show that acceptance does not depend on the address then. After an address has been assigned, matching and mismatching address fields are sent, and only the matching ones may strobe. Assignment writes are sent while the pin is held and again after it has been released, which separates the gate from the address check. A matching assignment that is dropped while the pin is held shows that the gate applies on its own. A write that clears the enable while the pin is held shows that only assignment writes are gated.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
    typedef enum logic [0:0] {
        ST_DEAF = 1'b0,
        ST_OPEN = 1'b1
    } pin_state_t;
endpackage

// File: rtl/cpf_addr_match.sv
module cpf_addr_match #(
    parameter int ADDR_W = 7
) (
    input  logic              chk_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              addr_ok
);
    always_comb begin
        addr_ok = (!chk_en) || (req_addr == own_addr);
    end
endmodule

// File: rtl/cpf_pin_fsm.sv
module cpf_pin_fsm
    import cpf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_release,
    output logic pin_open
);
    pin_state_t state_q;
    pin_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DEAF: if (pin_release)  state_d = ST_OPEN;
            ST_OPEN: if (!pin_release) state_d = ST_DEAF;
            default: state_d = ST_DEAF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_DEAF;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_OPEN: pin_open = 1'b1;
            default: pin_open = 1'b0;
        endcase
    end
endmodule

// File: rtl/cpf_cfg_reg.sv
module cpf_cfg_reg #(
    parameter int ADDR_W   = 7,
    parameter int IDX_W    = 3,
    parameter int DATA_W   = 8,
    parameter int CTRL_IDX = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              stb_q,
    output logic [IDX_W-1:0]  idx_q,
    output logic [DATA_W-1:0] data_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              en_q
);
    localparam int EN_BIT = DATA_W - 1;
    localparam logic [IDX_W-1:0] CTRL_SEL = IDX_W'(CTRL_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q  <= 1'b0;
            idx_q  <= '0;
            data_q <= '0;
            addr_q <= '0;
            en_q   <= 1'b0;
        end else begin
            stb_q <= accept;
            if (accept) begin
                idx_q  <= wr_idx;
                data_q <= wr_data;
                if (wr_idx == CTRL_SEL) begin
                    en_q   <= wr_data[EN_BIT];
                    addr_q <= wr_data[ADDR_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/ctrl_port_filter.sv
module ctrl_port_filter #(
    parameter int ADDR_W   = 7,
    parameter int IDX_W    = 3,
    parameter int DATA_W   = 8,
    parameter int CTRL_IDX = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_valid,
    input  logic [ADDR_W-1:0] xfer_addr,
    input  logic [IDX_W-1:0]  xfer_idx,
    input  logic [DATA_W-1:0] xfer_data,
    input  logic              pin_release,
    output logic              reg_wr_stb,
    output logic [IDX_W-1:0]  reg_wr_idx,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              dout_oe,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic              cfg_en
);
    localparam int EN_BIT = DATA_W - 1;
    localparam logic [IDX_W-1:0] CTRL_SEL = IDX_W'(CTRL_IDX);

    logic addr_ok;
    logic pin_open;
    logic is_assign;
    logic accept;

    cpf_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .chk_en  (cfg_en),
        .own_addr(cfg_addr),
        .req_addr(xfer_addr),
        .addr_ok (addr_ok)
    );

    cpf_pin_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_release(pin_release),
        .pin_open   (pin_open)
    );

    always_comb begin
        is_assign = (xfer_idx == CTRL_SEL) && xfer_data[EN_BIT];
        accept    = xfer_valid && addr_ok && (!is_assign || pin_open);
        dout_oe   = pin_open;
    end

    cpf_cfg_reg #(
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W),
        .DATA_W  (DATA_W),
        .CTRL_IDX(CTRL_IDX)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .wr_idx (xfer_idx),
        .wr_data(xfer_data),
        .stb_q  (reg_wr_stb),
        .idx_q  (reg_wr_idx),
        .data_q (reg_wr_data),
        .addr_q (cfg_addr),
        .en_q   (cfg_en)
    );
endmodule

// File: rtl/cpf_checker.sv
module cpf_checker #(
    parameter int ADDR_W   = 7,
    parameter int IDX_W    = 3,
    parameter int DATA_W   = 8,
    parameter int CTRL_IDX = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_valid,
    input logic [ADDR_W-1:0] xfer_addr,
    input logic [IDX_W-1:0]  xfer_idx,
    input logic [DATA_W-1:0] xfer_data,
    input logic              pin_release,
    input logic              reg_wr_stb,
    input logic [IDX_W-1:0]  reg_wr_idx,
    input logic              dout_oe,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              cfg_en
);
    localparam logic [IDX_W-1:0] CTRL_SEL = IDX_W'(CTRL_IDX);

    AST_STB_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid == 1'b0 |=> !reg_wr_stb);                                       // R2
    AST_MISMATCH_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && cfg_en && (xfer_addr != cfg_addr)) |=> !reg_wr_stb);        // R3
    AST_CFG_NEEDS_CTRL_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({cfg_en, cfg_addr}) |-> (reg_wr_stb && reg_wr_idx == CTRL_SEL));  // R4
    AST_ASSIGN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && xfer_idx == CTRL_SEL && xfer_data[DATA_W-1] && !dout_oe)
        |=> !reg_wr_stb);                                                          // R5
    AST_OE_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        pin_release |=> dout_oe);                                                  // R6
    AST_OE_DROPS_WITH_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_release |=> !dout_oe);                                                // R6
endmodule

bind ctrl_port_filter cpf_checker #(
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .DATA_W  (DATA_W),
    .CTRL_IDX(CTRL_IDX)
) u_cpf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_valid (xfer_valid),
    .xfer_addr  (xfer_addr),
    .xfer_idx   (xfer_idx),
    .xfer_data  (xfer_data),
    .pin_release(pin_release),
    .reg_wr_stb (reg_wr_stb),
    .reg_wr_idx (reg_wr_idx),
    .dout_oe    (dout_oe),
    .cfg_addr   (cfg_addr),
    .cfg_en     (cfg_en)
);

// File: tb/test_ctrl_port_filter.sv
`timescale 1ns/1ps
module test_ctrl_port_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xfer_valid = 1'b0;
    logic [6:0] xfer_addr = '0;
    logic [2:0] xfer_idx = '0;
    logic [7:0] xfer_data = '0;
    logic       pin_release = 1'b0;
    logic       reg_wr_stb;
    logic [2:0] reg_wr_idx;
    logic [7:0] reg_wr_data;
    logic       dout_oe;
    logic [6:0] cfg_addr;
    logic       cfg_en;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ctrl_port_filter i_ctrl_port_filter (
        .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_addr(xfer_addr),
        .xfer_idx(xfer_idx), .xfer_data(xfer_data), .pin_release(pin_release),
        .reg_wr_stb(reg_wr_stb), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
        .dout_oe(dout_oe), .cfg_addr(cfg_addr), .cfg_en(cfg_en)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [6:0] a, input logic [2:0] i, input logic [7:0] d,
                        input bit exp_stb, input string req);
        @(negedge clk);
        xfer_valid = 1'b1; xfer_addr = a; xfer_idx = i; xfer_data = d;
        @(negedge clk);
        xfer_valid = 1'b0;
        check(req, int'(reg_wr_stb), int'(exp_stb));
        if (exp_stb) begin
            check(req, int'(reg_wr_idx), int'(i));
            check(req, int'(reg_wr_data), int'(d));
        end
        @(negedge clk);
        check(req, int'(reg_wr_stb), 0);
    endtask

    task automatic check_cfg(input bit en, input logic [6:0] a, input string req);
        check(req, int'(cfg_en), int'(en));
        check(req, int'(cfg_addr), int'(a));
    endtask

    task automatic t_reset;
        check("R1", int'(reg_wr_stb), 0);
        check("R1", int'(dout_oe), 0);
        check_cfg(1'b0, 7'h00, "R1");
    endtask

    task automatic t_open_accept;
        send(7'h55, 3'd2, 8'hA3, 1'b1, "R2");
        send(7'h7F, 3'd5, 8'h01, 1'b1, "R2");
        check_cfg(1'b0, 7'h00, "R2");
    endtask

    task automatic t_blocked_assign;
        send(7'h00, 3'd7, 8'hAA, 1'b0, "R5");
        check_cfg(1'b0, 7'h00, "R5");
    endtask

    task automatic t_release_and_assign;
        @(negedge clk);
        pin_release = 1'b1;
        check("R6", int'(dout_oe), 0);
        @(negedge clk);
        check("R6", int'(dout_oe), 1);
        send(7'h10, 3'd7, 8'hAA, 1'b1, "R7");
        check_cfg(1'b1, 7'h2A, "R4");
        pin_release = 1'b0;
        check("R6", int'(dout_oe), 1);
        @(negedge clk);
        check("R6", int'(dout_oe), 0);
    endtask

    task automatic t_compare;
        send(7'h11, 3'd3, 8'h77, 1'b0, "R3");
        send(7'h11, 3'd7, 8'h05, 1'b0, "R3");
        check_cfg(1'b1, 7'h2A, "R3");
        send(7'h2A, 3'd3, 8'h5C, 1'b1, "R3");
    endtask

    task automatic t_matching_assign_held;
        send(7'h2A, 3'd7, 8'hB3, 1'b0, "R5");
        check_cfg(1'b1, 7'h2A, "R5");
    endtask

    task automatic t_disable_ungated;
        send(7'h2A, 3'd7, 8'h15, 1'b1, "R8");
        check_cfg(1'b0, 7'h15, "R8");
        send(7'h63, 3'd1, 8'hE4, 1'b1, "R2");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_open_accept();
        t_blocked_assign();
        t_release_and_assign();
        t_compare();
        t_matching_assign_held();
        t_disable_ungated();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule